// File: doc/BRIEF.md
# Threshold Consensus Element Bank

This block is a clocked model of a bank of generalized consensus elements with memory. Each lane watches K input bits and drives one state-holding output bit. A lane output is set when the number of its high inputs reaches the rise threshold. It is cleared when the number of its low inputs reaches the fall threshold. In every other case it keeps the value it already has.

The two thresholds are run-time configuration inputs shared by all lanes. Setting both thresholds to K gives the classic symmetric consensus gate, which waits for all inputs to agree. A rise threshold of K with a fall threshold of 1 gives an asymmetric element that needs full agreement to set but only one dissenting input to clear. Values in between give threshold-gate behaviour with hysteresis. Several independent lanes share the configuration, so one instance can join a group of request or acknowledge wires in a handshake controller.

Some threshold pairs let both conditions be true on the same inputs. When that happens in a lane, the lane keeps its output and the block raises a configuration-error flag. Reset loads each lane with its own initial value, given by a parameter.

Top module: `thresh_celem_bank`

## Requirements
- R1: With both thresholds set to K (K=4 by default), a lane output becomes 1 only when all four of its inputs are 1.
- R2: With both thresholds set to K, a lane output becomes 0 only when all of its inputs are 0. A mix of 1s and 0s leaves the output unchanged.
- R3: When the count of high inputs in a lane is at least `cfg_rise_thr` and the count of low inputs is below `cfg_fall_thr`, the lane output is 1 after the next rising clock edge.
- R4: When the count of low inputs in a lane is at least `cfg_fall_thr` and the count of high inputs is below `cfg_rise_thr`, the lane output is 0 after the next rising clock edge.
- R5: When neither condition holds, the lane output keeps its value.
- R6: With the rise threshold at K and the fall threshold at 1, a set lane is cleared by a single low input.
- R7: When both conditions hold in any lane, that lane keeps its output and `cfg_err` is 1 after the next edge. `cfg_err` is 0 after an edge at which no lane had both conditions.
- R8: While `rst_n` is low, and for two rising edges after it goes high, lane i output equals bit i of INIT_OUT (default 2'b10) and `cfg_err` is 0. The first edge at which inputs are evaluated is the third one after release.
- R9: Lanes are independent. Lane i uses input bits [i*K +: K], and activity on one lane does not change another lane's output.
- R10: The output is registered. Its new value is visible after the rising edge that samples the causing inputs, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rise_thr | input | CW ($clog2(K+1)) | Minimum count of high inputs that sets a lane |
| cfg_fall_thr | input | CW | Minimum count of low inputs that clears a lane |
| lane_in | input | LANES*K | Packed lane inputs, lane i at [i*K +: K] |
| lane_out | output | LANES | State-holding lane outputs |
| cfg_err | output | 1 | Rise and fall conditions were both true in some lane at the last edge |

## Verification
The checker tests the lane rules on every evaluated cycle. It counts each lane's high inputs, compares the counts with the two thresholds, and requires set, clear, hold or conflict-hold with a matching error flag one edge later. It only checks these rules while the synchronized reset is inactive. The bench scenarios cover the rest: the reset values, the two-edge release delay, the exact cycle in which an output changes, and named configurations (symmetric, middle threshold, asymmetric and conflicting), where specific input sequences must yield specific outputs.

// File: rtl/thresh_celem_pkg.sv
package thresh_celem_pkg;
  // Lane decision for one evaluation
  typedef enum logic [1:0] {
    ACT_HOLD     = 2'd0,
    ACT_SET      = 2'd1,
    ACT_CLEAR    = 2'd2,
    ACT_CONFLICT = 2'd3
  } lane_act_e;
endpackage

// File: rtl/thresh_rst_sync.sv
module thresh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/thresh_popcount.sv
module thresh_popcount #(
  parameter int K  = 4,
  parameter int CW = $clog2(K+1)
) (
  input  logic [K-1:0]  bits,
  output logic [CW-1:0] ones
);
  // Ripple accumulation chain, one stage per input bit
  logic [CW-1:0] acc [0:K];
  assign acc[0] = '0;
  for (genvar b = 0; b < K; b++) begin : g_acc
    assign acc[b+1] = acc[b] + CW'(bits[b]);
  end
  assign ones = acc[K];
endmodule

// File: rtl/thresh_lane.sv
module thresh_lane
  import thresh_celem_pkg::*;
#(
  parameter int   K    = 4,
  parameter int   CW   = $clog2(K+1),
  parameter logic INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_ok_n,
  input  logic [CW-1:0] rise_thr,
  input  logic [CW-1:0] fall_thr,
  input  logic [K-1:0]  din,
  output logic          q,
  output logic          conflict
);
  localparam logic [CW-1:0] K_CNT = CW'(K);

  logic [CW-1:0] n_high;
  logic [CW-1:0] n_low;
  logic          rise_ok;
  logic          fall_ok;
  lane_act_e     act;
  logic          q_en;
  logic          q_d;

  thresh_popcount #(.K(K), .CW(CW)) i_cnt (
    .bits (din),
    .ones (n_high)
  );

  assign n_low   = K_CNT - n_high;
  assign rise_ok = (n_high >= rise_thr);
  assign fall_ok = (n_low  >= fall_thr);

  always_comb begin
    unique case ({rise_ok, fall_ok})
      2'b10:   act = ACT_SET;
      2'b01:   act = ACT_CLEAR;
      2'b11:   act = ACT_CONFLICT;
      default: act = ACT_HOLD;
    endcase
  end

  // Next-state and enable
  always_comb begin
    q_en = 1'b0;
    q_d  = q;
    case (act)
      ACT_SET:   begin q_en = 1'b1; q_d = 1'b1; end
      ACT_CLEAR: begin q_en = 1'b1; q_d = 1'b0; end
      default:   begin q_en = 1'b0; q_d = q;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)  q <= INIT;
    else if (q_en)  q <= q_d;
  end

  assign conflict = (act == ACT_CONFLICT);
endmodule

// File: rtl/thresh_celem_bank.sv
module thresh_celem_bank #(
  parameter int               K        = 4,
  parameter int               LANES    = 2,
  parameter logic [LANES-1:0] INIT_OUT = 2'b10,
  parameter int               CW       = $clog2(K+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      cfg_rise_thr,
  input  logic [CW-1:0]      cfg_fall_thr,
  input  logic [LANES*K-1:0] lane_in,
  output logic [LANES-1:0]   lane_out,
  output logic               cfg_err
);
  logic             rst_ok_n;
  logic [LANES-1:0] lane_conf;
  logic             err_d;
  logic             err_en;

  thresh_rst_sync #(.STAGES(2)) i_rsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    thresh_lane #(.K(K), .CW(CW), .INIT(INIT_OUT[i])) i_lane (
      .clk      (clk),
      .rst_ok_n (rst_ok_n),
      .rise_thr (cfg_rise_thr),
      .fall_thr (cfg_fall_thr),
      .din      (lane_in[i*K +: K]),
      .q        (lane_out[i]),
      .conflict (lane_conf[i])
    );
  end

  always_comb begin
    err_en = 1'b1;
    err_d  = |lane_conf;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)   cfg_err <= 1'b0;
    else if (err_en) cfg_err <= err_d;
  end
endmodule

// File: rtl/thresh_celem_chk.sv
module thresh_celem_chk #(
  parameter int K     = 4,
  parameter int LANES = 2,
  parameter int CW    = 3
) (
  input logic               clk,
  input logic               rst_ok_n,
  input logic [CW-1:0]      rise_thr,
  input logic [CW-1:0]      fall_thr,
  input logic [LANES*K-1:0] lane_in,
  input logic [LANES-1:0]   lane_out,
  input logic               cfg_err
);
  logic [LANES-1:0] up_c;
  logic [LANES-1:0] dn_c;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assign up_c[i] = $countones(lane_in[i*K +: K]) >= int'(rise_thr);
    assign dn_c[i] = (K - $countones(lane_in[i*K +: K])) >= int'(fall_thr);

    // R3, R10: set one edge after sampling
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (up_c[i] && !dn_c[i]) |=> lane_out[i]);
    // R4, R10: clear one edge after sampling
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (dn_c[i] && !up_c[i]) |=> !lane_out[i]);
    // R5: hold when neither condition
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (!up_c[i] && !dn_c[i]) |=> $stable(lane_out[i]));
    // R7: conflict holds and flags
    a_r7_conflict: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (up_c[i] && dn_c[i]) |=> ($stable(lane_out[i]) && cfg_err));
  end

  // R7: flag clears when no lane conflicts
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((up_c & dn_c) == '0) |=> !cfg_err);
endmodule

bind thresh_celem_bank thresh_celem_chk #(.K(K), .LANES(LANES), .CW(CW)) i_chk (
  .clk      (clk),
  .rst_ok_n (rst_ok_n),
  .rise_thr (cfg_rise_thr),
  .fall_thr (cfg_fall_thr),
  .lane_in  (lane_in),
  .lane_out (lane_out),
  .cfg_err  (cfg_err)
);

// File: tb/test_thresh_celem_bank.sv
module test_thresh_celem_bank;
  localparam int K = 4;
  localparam int LANES = 2;
  localparam int CW = 3;

  logic             clk;
  logic             rst_n;
  logic [CW-1:0]    cfg_rise_thr;
  logic [CW-1:0]    cfg_fall_thr;
  logic [LANES*K-1:0] lane_in;
  logic [LANES-1:0] lane_out;
  logic             cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  thresh_celem_bank #(.K(K), .LANES(LANES), .INIT_OUT(2'b10)) i_thresh_celem_bank (
    .clk(clk), .rst_n(rst_n), .cfg_rise_thr(cfg_rise_thr), .cfg_fall_thr(cfg_fall_thr),
    .lane_in(lane_in), .lane_out(lane_out), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [LANES-1:0] exp_out, input logic exp_err);
    checks++;
    if (lane_out !== exp_out || cfg_err !== exp_err) begin
      failures++;
      $display("FAIL %s: out=%b err=%b expected out=%b err=%b", req, lane_out, cfg_err, exp_out, exp_err);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic [K-1:0] l1, input logic [K-1:0] l0,
                      input logic [LANES-1:0] exp_out, input logic exp_err, input string req);
    lane_in = {l1, l0};
    @(negedge clk);
    check(req, exp_out, exp_err);
  endtask

  task automatic set_thr(input int m, input int n);
    cfg_rise_thr = CW'(m);
    cfg_fall_thr = CW'(n);
  endtask

  task automatic t_reset;
    set_thr(4, 4);
    lane_in = '1;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 in reset", 2'b10, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 release edge 1", 2'b10, 1'b0);
    @(negedge clk);
    check("R8 release edge 2", 2'b10, 1'b0);
    @(negedge clk);
    check("R8 R10 first evaluated edge", 2'b11, 1'b0);
  endtask

  task automatic t_symmetric;
    set_thr(4, 4);
    step(4'b1111, 4'b1110, 2'b11, 1'b0, "R2 mixed holds");
    step(4'b0111, 4'b0000, 2'b10, 1'b0, "R2 all low clears, R9 lane1 holds");
    step(4'b0000, 4'b0001, 2'b00, 1'b0, "R2 lane1 clears, R1 lane0 no set");
    step(4'b1110, 4'b0111, 2'b00, 1'b0, "R1 three high no set");
    step(4'b1111, 4'b0111, 2'b10, 1'b0, "R1 all high sets, R9");
  endtask

  task automatic t_middle;
    set_thr(3, 3);
    step(4'b0001, 4'b1011, 2'b01, 1'b0, "R3 R4 count three sets and clears");
    step(4'b0011, 4'b0011, 2'b01, 1'b0, "R5 count two holds");
    step(4'b0111, 4'b1000, 2'b10, 1'b0, "R3 R4 swap");
  endtask

  task automatic t_asym;
    set_thr(4, 1);
    step(4'b1111, 4'b1111, 2'b11, 1'b0, "R6 all high sets");
    step(4'b1101, 4'b1111, 2'b01, 1'b0, "R6 single low clears");
    step(4'b1111, 4'b1111, 2'b11, 1'b0, "R6 reset again");
  endtask

  task automatic t_conflict;
    set_thr(2, 2);
    step(4'b0011, 4'b1111, 2'b11, 1'b1, "R7 conflict lane1 holds and flags");
    step(4'b0101, 4'b0000, 2'b10, 1'b1, "R7 conflict holds lane1, lane0 clears");
    step(4'b1110, 4'b0001, 2'b10, 1'b0, "R7 flag clears");
  endtask

  task automatic t_latency;
    set_thr(4, 4);
    lane_in = 8'h00;
    @(negedge clk);
    lane_in = 8'hFF;
    #1;
    check("R10 no change before edge", 2'b00, 1'b0);
    @(negedge clk);
    check("R10 change after edge", 2'b11, 1'b0);
  endtask

  initial begin
    lane_in = '0;
    set_thr(4, 4);
    t_reset();
    t_symmetric();
    t_middle();
    t_asym();
    t_conflict();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: expected done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule